// File: doc/BRIEF.md
# Chip-8 Register Arithmetic Execute Unit

This block carries out the register-to-register and register-immediate arithmetic of the Chip-8 virtual machine. It holds the sixteen 8-bit general registers V0 to VF and a one-bit processor flag that is not visible as a register. It accepts one 16-bit instruction at a time over a valid/ready handshake. The groups it executes are `7XNN` (add an immediate) and `8XYN` (move, bitwise logic, add, two subtractions and two shifts). When an instruction has finished, the block raises a one-cycle done pulse. Any other instruction is rejected: the block raises an illegal indication together with done and changes no state.

Each instruction is written back in a fixed order. The result goes to VX first, and then, for every 8-group operation except the move, VF receives the flag in bit 0 with zeros above it. The flag is a real register that persists between instructions. The bitwise operations leave it alone, so they copy whatever the last flag-producing instruction left into VF. A mode pin chooses whether the shifts read VY (legacy interpreters) or VX (later interpreters). A second mode pin stretches completion to the timing of the original interpreter. A combinational debug port reads any register.

Handshake rules: `instr_ready` is high only while the block is idle. An instruction is taken on a rising edge where `instr_valid` and `instr_ready` are both high. The source must hold `instr` steady while `instr_valid` is high and `instr_ready` is low. Nothing is accepted between acceptance and the cycle after done.

Top module: `chip8_alu_exec`

## Requirements
- R1: `7XNN` writes VX = (VX + NN) mod 256. Neither VF nor the hidden flag changes (VX=0xF1, NN=0x10 gives 0x01).
- R2: For the `8XYN` group, low nibble 0 copies VY to VX and leaves VF untouched. Nibbles 1, 2 and 3 write VX OR VY, VX AND VY and VX XOR VY respectively. VY is never modified.
- R3: Nibble 4 writes VX = (VX + VY) mod 256 and sets the flag to the carry out (0xED + 0x4B gives 0x38 with flag 1).
- R4: Nibble 5 writes VX = VX - VY mod 256. The flag is 1 when no borrow occurs, including equal operands, and 0 on a borrow.
- R5: Nibble 7 writes VX = VY - VX mod 256, with the same flag rule as R4.
- R6: With `shift_src_x`=0, nibble 6 writes VY>>1 to VX with the flag set to old bit 0 of VY. Nibble E writes VY<<1 to VX with the flag set to old bit 7 of VY. The old VX value plays no part.
- R7: With `shift_src_x`=1, both shifts take VX as the source instead of VY. Result and flag handling are otherwise the same.
- R8: Every 8-group operation except nibble 0 writes VF = {7'b0, flag} after the VX write. With X=F, VF therefore ends holding the flag, not the result.
- R9: Nibbles 1, 2 and 3 do not update the flag. The VF they write holds the flag from the most recent flag-producing operation.
- R10: No operation reads VF as a carry-in or borrow-in.
- R11: Top nibble other than 7 or 8, or 8-group low nibble 8 to D or F, gives `illegal`=1 during the done cycle and changes no register or flag.
- R12: `done` is a single-cycle pulse. With `cycle_exact`=0, done is seen 2 cycles after acceptance when VF is not written (`7XNN`, nibble 0, illegal), and 3 cycles after acceptance otherwise. `instr_ready` is low in between.
- R13: With `cycle_exact`=1 at acceptance, `7XNN` completes 10 cycles after acceptance and each VF-writing 8-group operation completes 44 cycles after acceptance. Other instructions keep the R12 timing.
- R14: Reset clears all registers to 0x00 and the flag to 0. The block comes out of reset idle with `instr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block idle and able to take an instruction |
| instr | input | 16 | Instruction word |
| shift_src_x | input | 1 | 1: shifts read VX; 0: shifts read VY |
| cycle_exact | input | 1 | 1: stretch completion to original timing |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with done when the instruction was rejected |
| dbg_addr | input | 4 | Debug register index |
| dbg_data | output | 8 | Contents of register `dbg_addr` |

## Verification
Two functions share a cycle in this block. The flag register updates on the same edge that writes VX. The following edge then writes VF, which takes over the VX result when X is F. The bench provokes the collision with an add whose destination is VF (0xF0 + 0x20) and expects VF to end at 0x01 rather than 0x10. It also runs a move into VF, where the result must survive because no flag write follows. Preloading VF with 0x80 before a bitwise operation separates a stale flag copy from an unchanged VF.

// File: rtl/chip8_alu_pkg.sv
package chip8_alu_pkg;

  typedef enum logic [3:0] {
    OP_IMM, OP_MOV, OP_OR, OP_AND, OP_XOR,
    OP_ADD, OP_SUB, OP_SHR, OP_SUBN, OP_SHL, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRX, ST_WRF, ST_HOLD, ST_FIN
  } st_e;

  function automatic op_e decode_op(input logic [15:0] ins);
    op_e o;
    o = OP_BAD;
    if (ins[15:12] == 4'h7) begin
      o = OP_IMM;
    end else if (ins[15:12] == 4'h8) begin
      case (ins[3:0])
        4'h0:    o = OP_MOV;
        4'h1:    o = OP_OR;
        4'h2:    o = OP_AND;
        4'h3:    o = OP_XOR;
        4'h4:    o = OP_ADD;
        4'h5:    o = OP_SUB;
        4'h6:    o = OP_SHR;
        4'h7:    o = OP_SUBN;
        4'hE:    o = OP_SHL;
        default: o = OP_BAD;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/chip8_regfile.sv
module chip8_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic [AW-1:0] raddr_d,
  output logic [DW-1:0] rdata_d
);

  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        q[g] <= wdata;
      end
    end
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
  assign rdata_d = q[raddr_d];

endmodule

// File: rtl/chip8_alu_core.sv
module chip8_alu_core
  import chip8_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] vx,
  input  logic [DW-1:0] vy,
  input  logic [DW-1:0] imm,
  input  logic          flag_in,
  input  logic          shift_src_x,
  output logic [DW-1:0] res,
  output logic          flag_out,
  output logic          flag_upd,
  output logic          wr_vx,
  output logic          wr_vf
);

  logic [DW:0]   sum_xy;
  logic [DW:0]   dif_xy;
  logic [DW:0]   dif_yx;
  logic [DW-1:0] sh_src;

  always_comb begin
    sum_xy = {1'b0, vx} + {1'b0, vy};
    dif_xy = {1'b0, vx} - {1'b0, vy};
    dif_yx = {1'b0, vy} - {1'b0, vx};
    sh_src = shift_src_x ? vx : vy;
  end

  always_comb begin
    res      = '0;
    flag_out = flag_in;
    flag_upd = 1'b0;
    wr_vx    = 1'b0;
    wr_vf    = 1'b0;
    case (op)
      OP_IMM: begin
        res   = vx + imm;
        wr_vx = 1'b1;
      end
      OP_MOV: begin
        res   = vy;
        wr_vx = 1'b1;
      end
      OP_OR: begin
        res   = vx | vy;
        wr_vx = 1'b1;
        wr_vf = 1'b1;
      end
      OP_AND: begin
        res   = vx & vy;
        wr_vx = 1'b1;
        wr_vf = 1'b1;
      end
      OP_XOR: begin
        res   = vx ^ vy;
        wr_vx = 1'b1;
        wr_vf = 1'b1;
      end
      OP_ADD: begin
        res      = sum_xy[DW-1:0];
        flag_out = sum_xy[DW];
        flag_upd = 1'b1;
        wr_vx    = 1'b1;
        wr_vf    = 1'b1;
      end
      OP_SUB: begin
        res      = dif_xy[DW-1:0];
        flag_out = ~dif_xy[DW];
        flag_upd = 1'b1;
        wr_vx    = 1'b1;
        wr_vf    = 1'b1;
      end
      OP_SUBN: begin
        res      = dif_yx[DW-1:0];
        flag_out = ~dif_yx[DW];
        flag_upd = 1'b1;
        wr_vx    = 1'b1;
        wr_vf    = 1'b1;
      end
      OP_SHR: begin
        res      = {1'b0, sh_src[DW-1:1]};
        flag_out = sh_src[0];
        flag_upd = 1'b1;
        wr_vx    = 1'b1;
        wr_vf    = 1'b1;
      end
      OP_SHL: begin
        res      = {sh_src[DW-2:0], 1'b0};
        flag_out = sh_src[DW-1];
        flag_upd = 1'b1;
        wr_vx    = 1'b1;
        wr_vf    = 1'b1;
      end
      default: begin
        res = '0;
      end
    endcase
  end

endmodule

// File: rtl/chip8_exec_ctrl.sv
module chip8_exec_ctrl
  import chip8_alu_pkg::*;
#(
  parameter int LAT_IMM = 10,
  parameter int LAT_ALU = 44,
  localparam int CW     = $clog2(LAT_ALU + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cycle_exact,
  input  logic is_imm,
  input  logic is_bad,
  input  logic need_vf,
  output logic ready,
  output logic ph_wrx,
  output logic ph_wrf,
  output logic done,
  output logic illegal
);

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          exact_q;
  logic [CW-1:0] last_hold;

  assign last_hold = is_imm ? CW'(LAT_IMM - 1) : CW'(LAT_ALU - 1);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_WRX;
      ST_WRX: begin
        if (is_bad)               st_d = ST_FIN;
        else if (need_vf)         st_d = ST_WRF;
        else if (exact_q && is_imm) st_d = ST_HOLD;
        else                      st_d = ST_FIN;
      end
      ST_WRF:  st_d = exact_q ? ST_HOLD : ST_FIN;
      ST_HOLD: if (cnt_q == last_hold) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      exact_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        if (start) begin
          cnt_q   <= CW'(1);
          exact_q <= cycle_exact;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign ready   = (st_q == ST_IDLE);
  assign ph_wrx  = (st_q == ST_WRX);
  assign ph_wrf  = (st_q == ST_WRF);
  assign done    = (st_q == ST_FIN);
  assign illegal = done && is_bad;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R12

  AST_VF_AFTER_VX: assert property (@(posedge clk) disable iff (!rst_n)
    ph_wrf |-> $past(ph_wrx));  // R8

  AST_EXACT_IMM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exact_q && is_imm) |-> (cnt_q == CW'(LAT_IMM)));  // R13

  AST_EXACT_ALU_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exact_q && need_vf) |-> (cnt_q == CW'(LAT_ALU)));  // R13

endmodule

// File: rtl/chip8_alu_exec.sv
module chip8_alu_exec
  import chip8_alu_pkg::*;
#(
  parameter int LAT_IMM = 10,
  parameter int LAT_ALU = 44
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  output logic        instr_ready,
  input  logic [15:0] instr,
  input  logic        shift_src_x,
  input  logic        cycle_exact,
  output logic        done,
  output logic        illegal,
  input  logic [3:0]  dbg_addr,
  output logic [7:0]  dbg_data
);

  localparam int NREG = 16;
  localparam int DW   = 8;
  localparam int AW   = $clog2(NREG);
  localparam logic [AW-1:0] VF_IDX = AW'(NREG - 1);

  logic [15:0]   instr_q;
  logic          flag_q;
  op_e           op;
  logic [AW-1:0] x_idx, y_idx;
  logic [DW-1:0] vx, vy, res;
  logic          flag_out, flag_upd, wr_vx, wr_vf;
  logic          start, ph_wrx, ph_wrf;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  assign start = instr_valid && instr_ready;
  assign op    = decode_op(instr_q);
  assign x_idx = instr_q[11:8];
  assign y_idx = instr_q[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (start) instr_q <= instr;
      if (ph_wrx && flag_upd) flag_q <= flag_out;
    end
  end

  chip8_alu_core #(.DW(DW)) u_core (
    .op         (op),
    .vx         (vx),
    .vy         (vy),
    .imm        (instr_q[7:0]),
    .flag_in    (flag_q),
    .shift_src_x(shift_src_x),
    .res        (res),
    .flag_out   (flag_out),
    .flag_upd   (flag_upd),
    .wr_vx      (wr_vx),
    .wr_vf      (wr_vf)
  );

  chip8_exec_ctrl #(.LAT_IMM(LAT_IMM), .LAT_ALU(LAT_ALU)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cycle_exact(cycle_exact),
    .is_imm     (op == OP_IMM),
    .is_bad     (op == OP_BAD),
    .need_vf    (wr_vf),
    .ready      (instr_ready),
    .ph_wrx     (ph_wrx),
    .ph_wrf     (ph_wrf),
    .done       (done),
    .illegal    (illegal)
  );

  always_comb begin
    rf_we    = (ph_wrx && wr_vx) || ph_wrf;
    rf_waddr = ph_wrf ? VF_IDX : x_idx;
    rf_wdata = ph_wrf ? {{(DW-1){1'b0}}, flag_q} : res;
  end

  chip8_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr_a(x_idx),
    .rdata_a(vx),
    .raddr_b(y_idx),
    .rdata_b(vy),
    .raddr_d(dbg_addr),
    .rdata_d(dbg_data)
  );

  AST_IMM_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_wrx && op == OP_IMM) |=> $stable(flag_q));  // R1

  AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_wrx && (op == OP_OR || op == OP_AND || op == OP_XOR)) |=> $stable(flag_q));  // R9

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_wrx && op == OP_BAD) |-> !rf_we);  // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_wrx || ph_wrf || done) |-> !instr_ready);  // R12

endmodule

// File: tb/chip8_alu_exec_tb.sv
module chip8_alu_exec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = '0;
  logic        shift_src_x = 1'b0;
  logic        cycle_exact = 1'b0;
  logic        done, illegal;
  logic [3:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;

  int checks = 0;
  int fails  = 0;
  bit pulse_ok = 1'b1;
  bit busy_ok  = 1'b1;

  always #5 clk = ~clk;

  chip8_alu_exec u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .shift_src_x(shift_src_x), .cycle_exact(cycle_exact),
    .done(done), .illegal(illegal), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // {low nibble, V1 init, V2 init, expected V1, expected VF}
  localparam logic [35:0] VEC [15] = '{
    {4'h4, 8'h2D, 8'h4B, 8'h78, 8'h00},
    {4'h4, 8'hED, 8'h4B, 8'h38, 8'h01},
    {4'h5, 8'h4B, 8'h2D, 8'h1E, 8'h01},
    {4'h5, 8'h2D, 8'h4B, 8'hE2, 8'h00},
    {4'h5, 8'h55, 8'h55, 8'h00, 8'h01},
    {4'h7, 8'h2D, 8'h4B, 8'h1E, 8'h01},
    {4'h7, 8'h4B, 8'h2D, 8'hE2, 8'h00},
    {4'h6, 8'hFF, 8'h2C, 8'h16, 8'h00},
    {4'h6, 8'h00, 8'h2D, 8'h16, 8'h01},
    {4'hE, 8'hFF, 8'h2D, 8'h5A, 8'h00},
    {4'hE, 8'h00, 8'hAD, 8'h5A, 8'h01},
    {4'h1, 8'h2D, 8'h4B, 8'h6F, 8'h01},
    {4'h2, 8'h2D, 8'h4B, 8'h09, 8'h01},
    {4'h3, 8'h2D, 8'h4B, 8'h66, 8'h01},
    {4'h0, 8'h2D, 8'hC3, 8'hC3, 8'h01}
  };

  function automatic string req_of(input logic [3:0] nib);
    case (nib)
      4'h4: return "R3";
      4'h5: return "R4";
      4'h7: return "R5";
      4'h6, 4'hE: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] r, output logic [7:0] v);
    dbg_addr = r;
    #1;
    v = dbg_data;
  endtask

  task automatic run(input logic [15:0] ins, output int lat, output logic ill);
    @(negedge clk);
    instr = ins;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    @(posedge clk);
    lat = 0;
    ill = 1'b0;
    forever begin
      @(negedge clk);
      if (lat == 0) instr_valid = 1'b0;
      lat++;
      if (done) begin
        ill = illegal;
        break;
      end
      if (instr_ready) busy_ok = 1'b0;
      if (lat > 100) break;
    end
    @(negedge clk);
    if (done) pulse_ok = 1'b0;
  endtask

  task automatic set_reg(input logic [3:0] r, input logic [7:0] v);
    logic [7:0] c;
    int l;
    logic i;
    rd(r, c);
    run({4'h7, r, 8'(v - c)}, l, i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic ill;
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    for (int r = 0; r < 16; r++) begin
      rd(4'(r), v);
      chk("R14", "reset register", v, 0);
    end
    chk("R14", "ready after reset", instr_ready, 1);
    chk("R14", "done after reset", done, 0);
    run(16'h8121, lat, ill);
    rd(4'hF, v);
    chk("R14", "reset flag through VF", v, 8'h00);

    // R1 immediate add wraps, VF untouched
    set_reg(4'h3, 8'hF1);
    run(16'h7310, lat, ill);
    rd(4'h3, v);
    chk("R1", "7310 on 0xF1", v, 8'h01);
    rd(4'hF, v);
    chk("R1", "VF unchanged", v, 8'h00);
    chk("R12", "7XNN latency", lat, 2);

    // table walk: X=1, Y=2
    foreach (VEC[k]) begin
      logic [3:0] nib;
      nib = VEC[k][35:32];
      set_reg(4'h1, VEC[k][31:24]);
      set_reg(4'h2, VEC[k][23:16]);
      run({12'h812, nib}, lat, ill);
      rd(4'h1, v);
      chk(req_of(nib), "VX result", v, VEC[k][15:8]);
      rd(4'hF, v);
      chk(nib == 4'h0 ? "R2" : "R8", "VF after op", v, VEC[k][7:0]);
      rd(4'h2, v);
      chk("R2", "VY unchanged", v, VEC[k][23:16]);
      chk("R12", "latency", lat, nib == 4'h0 ? 2 : 3);
      chk("R11", "no illegal on valid op", ill, 0);
    end
    chk("R12", "ready low while busy", busy_ok, 1);

    // R9 stale flag copied by logic op (flag is 1 from last shift)
    set_reg(4'hF, 8'h80);
    set_reg(4'h1, 8'h0F);
    set_reg(4'h2, 8'hF0);
    run(16'h8121, lat, ill);
    rd(4'h1, v);
    chk("R9", "OR result", v, 8'hFF);
    rd(4'hF, v);
    chk("R9", "stale flag in VF", v, 8'h01);

    // R10 VF=1 not used as carry-in
    set_reg(4'h1, 8'h10);
    set_reg(4'h2, 8'h20);
    run(16'h8124, lat, ill);
    rd(4'h1, v);
    chk("R10", "add ignores VF", v, 8'h30);
    rd(4'hF, v);
    chk("R10", "flag after add", v, 8'h00);

    // R8 destination VF: flag overwrites result
    set_reg(4'hF, 8'hF0);
    set_reg(4'h2, 8'h20);
    run(16'h8F24, lat, ill);
    rd(4'hF, v);
    chk("R8", "X=F add leaves flag", v, 8'h01);
    run(16'h8F20, lat, ill);
    rd(4'hF, v);
    chk("R8", "X=F move keeps result", v, 8'h20);

    // R7 shifts from VX
    shift_src_x = 1'b1;
    set_reg(4'h1, 8'h2D);
    set_reg(4'h2, 8'hFF);
    run(16'h812E, lat, ill);
    rd(4'h1, v);
    chk("R7", "SHL from VX", v, 8'h5A);
    rd(4'hF, v);
    chk("R7", "SHL flag", v, 8'h00);
    set_reg(4'h1, 8'h81);
    set_reg(4'h2, 8'h00);
    run(16'h8126, lat, ill);
    rd(4'h1, v);
    chk("R7", "SHR from VX", v, 8'h40);
    rd(4'hF, v);
    chk("R7", "SHR flag", v, 8'h01);
    shift_src_x = 1'b0;

    // R11 illegal encodings
    set_reg(4'h1, 8'h77);
    run(16'h8128, lat, ill);
    chk("R11", "8XY8 illegal", ill, 1);
    chk("R11", "illegal latency", lat, 2);
    rd(4'h1, v);
    chk("R11", "VX unchanged", v, 8'h77);
    rd(4'hF, v);
    chk("R11", "VF unchanged", v, 8'h01);
    run(16'h812F, lat, ill);
    chk("R11", "8XYF illegal", ill, 1);
    run(16'h1234, lat, ill);
    chk("R11", "group 1 illegal", ill, 1);
    rd(4'h1, v);
    chk("R11", "VX still unchanged", v, 8'h77);
    run(16'h8125, lat, ill);
    rd(4'hF, v);
    chk("R11", "flag intact after illegal (77-00)", v, 8'h01);

    // R13 cycle-exact timing
    cycle_exact = 1'b1;
    run(16'h7105, lat, ill);
    chk("R13", "7XNN exact latency", lat, 10);
    run(16'h8124, lat, ill);
    chk("R13", "8XY4 exact latency", lat, 44);
    run(16'h8120, lat, ill);
    chk("R13", "8XY0 exact latency", lat, 2);
    cycle_exact = 1'b0;

    chk("R12", "done single pulse", pulse_ok, 1);
    chk("R12", "ready low while busy overall", busy_ok, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule